// File: doc/BRIEF.md
# Line-Scan Sensor Readout Controller

This block runs a line-scan image sensor that has a digital output. It makes the sensor clock from the system clock with a programmable half-period divider. On a start request it drives an active-low start pulse of fixed length. It then collects the serial pixel bits that the sensor sends on a data line, each bit marked by a falling edge of a data-trigger strobe. Every group of bits ends with an active-low end-of-conversion pulse, which moves the collected word to a valid/ready output stream along with its pixel position and a last-pixel flag.

The sensor-side inputs are asynchronous. Each one passes through a two-flop synchroniser, and edges are found in the system clock domain, so the system clock must run at least four times faster than the strobe. Each start yields a fixed number of pixels. A start request that arrives while a line is running is ignored. Two sticky flags report malformed words and words lost because the consumer was not ready. Both flags clear when the next line starts.

Top module: `lsens_readout`

## Requirements
- R1: `sens_clk` stays high for `clk_half` system clocks and then low for `clk_half` system clocks, for any `clk_half` of 1 or more. A value of 4 gives divide-by-8.
- R2: When `start_req` is high on a clock edge while `busy` is low, `sens_st_n` falls and `busy` rises on that same edge.
- R3: `sens_st_n` stays low across exactly START_CLKS (default 45) rising edges of `sens_clk`, and it returns high on the next rising edge.
- R4: While `busy` is high, `start_req` has no effect: `sens_st_n` stays high and the sticky flags keep their values.
- R5: Data is sampled on each synchronised falling edge of `sens_trig` and shifted in most-significant bit first. The word width is 10 bits when `mode10` is 1 and 8 bits when it is 0, using the value of `mode10` at the accepted start. An 8-bit word appears on `pix_data[7:0]` with bits 9:8 set to zero.
- R6: Each falling edge of `sens_eoc_n` during a line produces one word. Its `pix_index` equals the number of end-of-conversion pulses that came before it in the line, counting from 0.
- R7: A line ends after exactly LINE_PIX (default 1024) words. `pix_eol` is high only on the word with index LINE_PIX-1, and `busy` falls on the edge that takes that last end-of-conversion pulse.
- R8: An end-of-conversion pulse while `busy` is low produces no output word.
- R9: An end-of-conversion pulse after a bit count that differs from the selected width sets `frame_err`, which then stays set. The word (its last bits received, right-aligned) is still emitted.
- R10: If a word completes while `pix_valid` is high and `pix_ready` is low, `overrun` is set and stays set, and the new word is dropped. The held word is not changed, and later words keep their correct indices.
- R11: `frame_err` and `overrun` clear to 0 on the edge that accepts a start.
- R12: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_data`, `pix_index` and `pix_eol` hold their values.
- R13: After reset, `sens_st_n` is 1, and `busy`, `pix_valid`, `frame_err` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_half | input | HALF_W (8) | Sensor clock half-period in system clocks |
| mode10 | input | 1 | 1 selects 10-bit words, 0 selects 8-bit words |
| start_req | input | 1 | Request to start a line |
| sens_clk | output | 1 | Clock to the sensor |
| sens_st_n | output | 1 | Active-low start pulse to the sensor |
| sens_trig | input | 1 | Data-trigger strobe from the sensor, idles high |
| sens_dout | input | 1 | Serial pixel data from the sensor |
| sens_eoc_n | input | 1 | Active-low end-of-conversion pulse |
| busy | output | 1 | High while a line is in progress |
| pix_valid | output | 1 | Output word is valid |
| pix_ready | input | 1 | Consumer accepts the word |
| pix_data | output | 10 | Pixel word |
| pix_index | output | IDX_W (10) | Pixel position in the line |
| pix_eol | output | 1 | Last pixel of the line |
| frame_err | output | 1 | Sticky bit-count mismatch flag |
| overrun | output | 1 | Sticky dropped-word flag |

## Verification
A bit counter or shift register that has drifted shows up on the very next word, either as wrong `pix_data` or as a false `frame_err`. The bench compares every word of two full lines against its own model. A pixel counter that has slipped appears as a wrong `pix_index` on every later word, and as `pix_eol` and the fall of `busy` arriving at the wrong end-of-conversion pulse. A fault in the start-pulse counter shows directly as the number of sensor clock edges counted while `sens_st_n` is low. A hold or drop fault in the output stage shows within the stall window as a changed held word, a missing `overrun`, or an extra word in the stream.

// File: rtl/lsens_pkg.sv
package lsens_pkg;

  localparam int PIX_W = 10;
  localparam int BCNT_W = 4;

  typedef enum logic [1:0] {
    LN_IDLE  = 2'd0,
    LN_START = 2'd1,
    LN_RUN   = 2'd2
  } line_st_e;

  function automatic logic [BCNT_W-1:0] word_bits(input logic m10);
    return m10 ? BCNT_W'(10) : BCNT_W'(8);
  endfunction

endpackage

// File: rtl/lsens_clkgen.sv
module lsens_clkgen #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half,
  output logic              sclk,
  output logic              rise
);

  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              sclk_q, sclk_d;
  logic              wrap;

  always_comb begin
    wrap   = ({1'b0, cnt_q} + (HALF_W+1)'(1)) >= {1'b0, half};
    cnt_d  = wrap ? '0 : cnt_q + HALF_W'(1);
    sclk_d = wrap ? ~sclk_q : sclk_q;
    rise   = wrap && !sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;

endmodule

// File: rtl/lsens_deser.sv
module lsens_deser
  import lsens_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             dout,
  input  logic             eoc_n,
  input  logic             clr,
  input  logic             m10,
  output logic             word_evt,
  output logic [PIX_W-1:0] word,
  output logic             frame_bad
);

  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw;
  logic [NSYNC-1:0] s1_q, s2_q, prev_q;
  logic             trig_fall;
  logic [PIX_W-1:0]  shift_q, shift_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;

  assign raw = {eoc_n, dout, trig};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[g]   <= 1'b1;
        s2_q[g]   <= 1'b1;
        prev_q[g] <= 1'b1;
      end else begin
        s1_q[g]   <= raw[g];
        s2_q[g]   <= s1_q[g];
        prev_q[g] <= s2_q[g];
      end
    end
  end

  always_comb begin
    trig_fall = prev_q[0] && !s2_q[0];
    word_evt  = prev_q[2] && !s2_q[2];
    shift_d   = shift_q;
    bcnt_d    = bcnt_q;
    if (clr || word_evt) begin
      shift_d = '0;
      bcnt_d  = '0;
    end else if (trig_fall) begin
      shift_d = {shift_q[PIX_W-2:0], s2_q[1]};
      if (bcnt_q != '1) bcnt_d = bcnt_q + BCNT_W'(1);
    end
    word      = m10 ? shift_q : {{(PIX_W-8){1'b0}}, shift_q[7:0]};
    frame_bad = bcnt_q != word_bits(m10);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      bcnt_q  <= '0;
    end else begin
      shift_q <= shift_d;
      bcnt_q  <= bcnt_d;
    end
  end

endmodule

// File: rtl/lsens_linectl.sv
module lsens_linectl
  import lsens_pkg::*;
#(
  parameter int LINE_PIX   = 1024,
  parameter int START_CLKS = 45,
  parameter int IDX_W      = $clog2(LINE_PIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             sclk_rise,
  input  logic             word_evt,
  output logic             st_n,
  output logic             busy,
  output logic             accept,
  output logic             take,
  output logic [IDX_W-1:0] idx,
  output logic             last
);

  localparam int SC_W = $clog2(START_CLKS + 1);

  line_st_e         st_q, st_d;
  logic [SC_W-1:0]  scnt_q, scnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             stn_q, stn_d;

  always_comb begin
    st_d   = st_q;
    scnt_d = scnt_q;
    idx_d  = idx_q;
    stn_d  = stn_q;
    accept = (st_q == LN_IDLE) && start_req;
    take   = (st_q != LN_IDLE) && word_evt;
    last   = idx_q == IDX_W'(LINE_PIX - 1);
    case (st_q)
      LN_IDLE: begin
        if (start_req) begin
          st_d   = LN_START;
          scnt_d = '0;
          idx_d  = '0;
          stn_d  = 1'b0;
        end
      end
      LN_START: begin
        if (sclk_rise) begin
          if (scnt_q == SC_W'(START_CLKS)) begin
            st_d  = LN_RUN;
            stn_d = 1'b1;
          end else begin
            scnt_d = scnt_q + SC_W'(1);
          end
        end
      end
      default: ;
    endcase
    if (take) begin
      if (last) begin
        st_d  = LN_IDLE;
        idx_d = '0;
        stn_d = 1'b1;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LN_IDLE;
      scnt_q <= '0;
      idx_q  <= '0;
      stn_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      scnt_q <= scnt_d;
      idx_q  <= idx_d;
      stn_q  <= stn_d;
    end
  end

  assign st_n = stn_q;
  assign busy = st_q != LN_IDLE;
  assign idx  = idx_q;

endmodule

// File: rtl/lsens_readout.sv
module lsens_readout
  import lsens_pkg::*;
#(
  parameter int LINE_PIX   = 1024,
  parameter int START_CLKS = 45,
  parameter int HALF_W     = 8,
  parameter int IDX_W      = $clog2(LINE_PIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] clk_half,
  input  logic              mode10,
  input  logic              start_req,
  output logic              sens_clk,
  output logic              sens_st_n,
  input  logic              sens_trig,
  input  logic              sens_dout,
  input  logic              sens_eoc_n,
  output logic              busy,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [PIX_W-1:0]  pix_data,
  output logic [IDX_W-1:0]  pix_index,
  output logic              pix_eol,
  output logic              frame_err,
  output logic              overrun
);

  logic [1:0]       rsync_q;
  logic             rst_i_n;
  logic             sclk_rise, accept, take, last;
  logic             word_evt, frame_bad;
  logic [PIX_W-1:0] word;
  logic [IDX_W-1:0] idx;
  logic             m10_q, m10_d;
  logic             pv_q, pv_d, eol_q, eol_d, ferr_q, ferr_d, ovr_q, ovr_d;
  logic [PIX_W-1:0] pd_q, pd_d;
  logic [IDX_W-1:0] pi_q, pi_d;
  logic             load, drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  lsens_clkgen #(.HALF_W(HALF_W)) i_clkgen (
    .clk  (clk),
    .rst_n(rst_i_n),
    .half (clk_half),
    .sclk (sens_clk),
    .rise (sclk_rise)
  );

  lsens_linectl #(
    .LINE_PIX  (LINE_PIX),
    .START_CLKS(START_CLKS),
    .IDX_W     (IDX_W)
  ) i_linectl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start_req(start_req),
    .sclk_rise(sclk_rise),
    .word_evt (word_evt),
    .st_n     (sens_st_n),
    .busy     (busy),
    .accept   (accept),
    .take     (take),
    .idx      (idx),
    .last     (last)
  );

  lsens_deser i_deser (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .trig     (sens_trig),
    .dout     (sens_dout),
    .eoc_n    (sens_eoc_n),
    .clr      (accept),
    .m10      (m10_q),
    .word_evt (word_evt),
    .word     (word),
    .frame_bad(frame_bad)
  );

  always_comb begin
    load   = take && (!pv_q || pix_ready);
    drop   = take && pv_q && !pix_ready;
    m10_d  = accept ? mode10 : m10_q;
    pv_d   = load ? 1'b1 : (pix_ready ? 1'b0 : pv_q);
    pd_d   = load ? word : pd_q;
    pi_d   = load ? idx  : pi_q;
    eol_d  = load ? last : eol_q;
    ferr_d = accept ? 1'b0 : (ferr_q || (take && frame_bad));
    ovr_d  = accept ? 1'b0 : (ovr_q || drop);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      m10_q  <= 1'b0;
      pv_q   <= 1'b0;
      pd_q   <= '0;
      pi_q   <= '0;
      eol_q  <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      m10_q  <= m10_d;
      pv_q   <= pv_d;
      pd_q   <= pd_d;
      pi_q   <= pi_d;
      eol_q  <= eol_d;
      ferr_q <= ferr_d;
      ovr_q  <= ovr_d;
    end
  end

  assign pix_valid = pv_q;
  assign pix_data  = pd_q;
  assign pix_index = pi_q;
  assign pix_eol   = eol_q;
  assign frame_err = ferr_q;
  assign overrun   = ovr_q;

endmodule

// File: rtl/lsens_readout_chk.sv
module lsens_readout_chk #(
  parameter int LINE_PIX = 1024,
  parameter int IDX_W    = $clog2(LINE_PIX)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sens_st_n,
  input logic             busy,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic [9:0]       pix_data,
  input logic [IDX_W-1:0] pix_index,
  input logic             pix_eol,
  input logic             frame_err,
  input logic             overrun
);

  p_st_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sens_st_n |-> busy);

  p_st_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sens_st_n) |-> $rose(busy));

  p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !$fell(sens_st_n));

  p_eol_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_eol) |-> (pix_index == IDX_W'(LINE_PIX - 1)));

  p_ferr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_err) |-> $fell(sens_st_n));

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $fell(sens_st_n));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) &&
                                   $stable(pix_index) && $stable(pix_eol)));

endmodule

bind lsens_readout lsens_readout_chk #(.LINE_PIX(LINE_PIX), .IDX_W(IDX_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sens_st_n(sens_st_n),
  .busy     (busy),
  .pix_valid(pix_valid),
  .pix_ready(pix_ready),
  .pix_data (pix_data),
  .pix_index(pix_index),
  .pix_eol  (pix_eol),
  .frame_err(frame_err),
  .overrun  (overrun)
);

// File: tb/test_lsens_readout.sv
`timescale 1ns/1ps
module test_lsens_readout;

  localparam int LP = 1024;
  localparam int SC = 45;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] clk_half = 8'd4;
  logic       mode10 = 1'b0;
  logic       start_req = 1'b0;
  logic       sens_trig = 1'b1;
  logic       sens_dout = 1'b0;
  logic       sens_eoc_n = 1'b1;
  logic       pix_ready = 1'b1;
  logic       sens_clk, sens_st_n, busy, pix_valid, pix_eol, frame_err, overrun;
  logic [9:0] pix_data;
  logic [9:0] pix_index;

  int n_chk = 0;
  int n_fail = 0;
  int exp_data[$];
  int exp_idx[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lsens_readout i_lsens_readout (
    .clk(clk), .rst_n(rst_n), .clk_half(clk_half), .mode10(mode10),
    .start_req(start_req), .sens_clk(sens_clk), .sens_st_n(sens_st_n),
    .sens_trig(sens_trig), .sens_dout(sens_dout), .sens_eoc_n(sens_eoc_n),
    .busy(busy), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .pix_index(pix_index), .pix_eol(pix_eol),
    .frame_err(frame_err), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Output monitor: one transfer per sample with valid and ready high
  always @(negedge clk) begin
    if (rst_n && pix_valid && pix_ready) begin
      if (exp_data.size() == 0) begin
        chk(1'b0, "R8 unexpected word", int'(pix_data), -1);
      end else begin
        automatic int ed = exp_data.pop_front();
        automatic int ei = exp_idx.pop_front();
        chk(int'(pix_data) == ed, "R5 word value", int'(pix_data), ed);
        chk(int'(pix_index) == ei, "R6 pixel index", int'(pix_index), ei);
        chk(pix_eol == (ei == LP - 1), "R7 end-of-line flag", int'(pix_eol), int'(ei == LP - 1));
      end
    end
  end

  task automatic send_pixel(input int val, input int nbits, input bit expect_out, input int idx);
    for (int b = nbits - 1; b >= 0; b--) begin
      @(negedge clk) sens_dout = val[b];
      @(negedge clk) sens_trig = 1'b0;
      repeat (2) @(negedge clk);
      sens_trig = 1'b1;
    end
    @(negedge clk) sens_eoc_n = 1'b0;
    repeat (2) @(negedge clk);
    sens_eoc_n = 1'b1;
    if (expect_out) begin
      exp_data.push_back(val & ((1 << nbits) - 1));
      exp_idx.push_back(idx);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic test_reset;
    repeat (4) @(negedge clk);
    chk(sens_st_n == 1'b1, "R13 start idle", int'(sens_st_n), 1);
    chk(busy == 1'b0, "R13 busy", int'(busy), 0);
    chk(pix_valid == 1'b0, "R13 valid", int'(pix_valid), 0);
    chk(frame_err == 1'b0 && overrun == 1'b0, "R13 flags", int'({frame_err, overrun}), 0);
  endtask

  task automatic measure_half(input int h);
    int hi = 0;
    int lo = 0;
    logic prev;
    repeat (20) @(negedge clk);
    prev = sens_clk;
    @(negedge clk);
    while (!(sens_clk && !prev)) begin
      prev = sens_clk;
      @(negedge clk);
    end
    while (sens_clk) begin hi++; @(negedge clk); end
    while (!sens_clk) begin lo++; @(negedge clk); end
    chk(hi == h, "R1 high time", hi, h);
    chk(lo == h, "R1 low time", lo, h);
  endtask

  task automatic test_clock;
    measure_half(4);
    clk_half = 8'd2;
    measure_half(2);
    clk_half = 8'd4;
    measure_half(4);
  endtask

  task automatic test_idle_eoc;
    send_pixel(8'h5A, 8, 1'b0, 0);
    repeat (4) @(negedge clk);
    chk(pix_valid == 1'b0, "R8 idle end-of-conversion", int'(pix_valid), 0);
  endtask

  task automatic start_line(input bit count_edges);
    int edges = 0;
    logic prev;
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    chk(sens_st_n == 1'b0, "R2 start low", int'(sens_st_n), 0);
    chk(busy == 1'b1, "R2 busy high", int'(busy), 1);
    chk(frame_err == 1'b0 && overrun == 1'b0, "R11 flags cleared", int'({frame_err, overrun}), 0);
    prev = sens_clk;
    while (!sens_st_n) begin
      @(negedge clk);
      if (!sens_st_n && sens_clk && !prev) edges++;
      prev = sens_clk;
    end
    if (count_edges) chk(edges == SC, "R3 start width", edges, SC);
    repeat (10) @(negedge clk);
  endtask

  task automatic test_line8;
    mode10 = 1'b0;
    start_line(1'b1);
    for (int i = 0; i < LP; i++) begin
      automatic int v = (i * 37 + 5) & 255;
      if (i == 5) begin
        chk(frame_err == 1'b0, "R9 no error before", int'(frame_err), 0);
        send_pixel(v, 7, 1'b1, i);
        repeat (2) @(negedge clk);
        chk(frame_err == 1'b1, "R9 short word flagged", int'(frame_err), 1);
      end else if (i == 10) begin
        pix_ready = 1'b0;
        send_pixel(v, 8, 1'b1, i);
        send_pixel((i * 37 + 42) & 255, 8, 1'b0, i + 1);
        repeat (2) @(negedge clk);
        chk(overrun == 1'b1, "R10 overrun set", int'(overrun), 1);
        chk(pix_valid == 1'b1 && pix_index == 10'd10, "R12 held word", int'(pix_index), 10);
        chk(int'(pix_data) == v, "R10 held data kept", int'(pix_data), v);
        pix_ready = 1'b1;
        i++;
      end else if (i == 20) begin
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(sens_st_n == 1'b1 && busy == 1'b1, "R4 start ignored", int'(sens_st_n), 1);
        chk(frame_err && overrun, "R4 flags kept", int'({frame_err, overrun}), 3);
        send_pixel(v, 8, 1'b1, i);
      end else begin
        send_pixel(v, 8, 1'b1, i);
      end
    end
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R7 busy ends after last word", int'(busy), 0);
    chk(exp_data.size() == 0, "R7 all words delivered", exp_data.size(), 0);
    send_pixel(8'h33, 8, 1'b0, 0);
    repeat (4) @(negedge clk);
    chk(pix_valid == 1'b0, "R8 after line", int'(pix_valid), 0);
  endtask

  task automatic test_line10;
    mode10 = 1'b1;
    start_line(1'b0);
    for (int i = 0; i < LP; i++) begin
      automatic int v = (i * 13 + 1) & 1023;
      if (i == 100) mode10 = 1'b0;
      send_pixel(v, 10, 1'b1, i);
      if (i == 100) mode10 = 1'b1;
    end
    repeat (4) @(negedge clk);
    chk(frame_err == 1'b0, "R5 width latched at start", int'(frame_err), 0);
    chk(overrun == 1'b0, "R10 no overrun when ready", int'(overrun), 0);
    chk(busy == 1'b0, "R7 second line ends", int'(busy), 0);
    chk(exp_data.size() == 0, "R6 all ten-bit words", exp_data.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_clock();
    test_idle_eoc();
    test_line8();
    test_line10();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual running expected finished");
      report();
    end
  end

endmodule